// File: doc/BRIEF.md
# PLL Lock Monitor with Serializer Load Enable

This block turns the raw lock indication of a PLL into a filtered lock status. The raw flag is first synchronized into the local clock domain. A two-state machine then asks for a programmable number of consecutive samples at the new level before it changes state. One 8-bit wait count governs the move into the locked state and a second, independent one governs the move back out. This hysteresis keeps a chattering lock detector from toggling the downstream logic.

The filtered status drives the load-enable input of a serializer. Two override controls can pin that enable high or low, and the low override wins. An 8-bit event counter records how many times the locked state has been entered. The synchronized raw flag is also brought out unfiltered so it can be observed.

Top module: `pll_lock_filter`

## Requirements
- R1: With lock-wait value N applied, `lock_status_o` rises at the clock edge that takes the (N+1)-th consecutive high sample of the synchronized flag. A raw high first applied before edge k gives its first sample at edge k+2, so the rise comes after edge k+2+N.
- R2: With unlock-wait value M applied, `lock_status_o` falls at the edge that takes the (M+1)-th consecutive low sample of the synchronized flag.
- R3: Any single sample at the current-state level clears the qualification count. A run interrupted by even one such sample does not cause a transition, however long the total.
- R4: `lock_count_o` increases by one on each entry to the locked state, does not change otherwise, and wraps from 255 to 0.
- R5: `lock_raw_o` is the raw input delayed by the two-flop synchronizer, so it follows `lock_raw_i` two clock edges later.
- R6: With both overrides low, `load_en_o` equals `lock_status_o`.
- R7: With `force_en_hi_i` high and `force_en_lo_i` low, `load_en_o` is 1 whatever the lock status.
- R8: With `force_en_lo_i` high, `load_en_o` is 0 whatever `force_en_hi_i` and the lock status are.
- R9: While `rst_n` is low, `lock_status_o`, `lock_raw_o` and `lock_count_o` are 0, and the qualification count is cleared.
- R10: A wait value of 0 makes the transition on the first sample at the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_raw_i | input | 1 | Unfiltered PLL lock flag (asynchronous) |
| lock_wait_i | input | 8 | Extra high samples needed to enter the locked state |
| unlock_wait_i | input | 8 | Extra low samples needed to leave the locked state |
| force_en_hi_i | input | 1 | Override: drive load enable high |
| force_en_lo_i | input | 1 | Override: drive load enable low (has priority) |
| lock_status_o | output | 1 | Filtered lock status |
| lock_raw_o | output | 1 | Synchronized, unfiltered lock flag |
| lock_count_o | output | 8 | Number of entries to the locked state, modulo 256 |
| load_en_o | output | 1 | Serializer load enable |

## Verification
The assertions check the following on every cycle:
- the load-enable selection, including the priority of the low override;
- that the counter steps exactly on each rising edge of the status and holds otherwise;
- that every rise or fall of the status follows a synchronized sample of the matching level;
- that a zero wait value switches the state on the next edge.

Only the bench scenarios can show:
- the exact edge at which a nonzero wait count is met;
- that a single interrupting sample restarts qualification;
- the synchronizer latency;
- the counter wrap after 256 entries.

// File: rtl/plf_pkg.sv
package plf_pkg;
   typedef enum logic {
      ST_UNLOCKED = 1'b0,
      ST_LOCKED   = 1'b1
   } plf_state_e;
endpackage

// File: rtl/plf_sync.sv
module plf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/plf_qualifier.sv
module plf_qualifier
   import plf_pkg::*;
#(
   parameter int WAIT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flag_i,
   input  logic [WAIT_W-1:0] enter_wait_i,
   input  logic [WAIT_W-1:0] leave_wait_i,
   output logic              locked_o,
   output logic              enter_o
);
   plf_state_e        state_q;
   logic [WAIT_W-1:0] qual_q;
   logic              opposite;
   logic [WAIT_W-1:0] limit;
   logic              hit;

   always_comb begin
      opposite = (state_q == ST_LOCKED) ? !flag_i : flag_i;
      limit    = (state_q == ST_LOCKED) ? leave_wait_i : enter_wait_i;
      hit      = opposite && (qual_q >= limit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_UNLOCKED;
         qual_q  <= '0;
      end else if (hit) begin
         state_q <= (state_q == ST_LOCKED) ? ST_UNLOCKED : ST_LOCKED;
         qual_q  <= '0;
      end else if (opposite) begin
         qual_q  <= qual_q + 1'b1;
      end else begin
         qual_q  <= '0;
      end
   end

   assign locked_o = (state_q == ST_LOCKED);
   assign enter_o  = hit && (state_q == ST_UNLOCKED);
endmodule

// File: rtl/plf_event_counter.sv
module plf_event_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     count_o <= '0;
      else if (inc_i) count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/plf_load_enable.sv
module plf_load_enable (
   input  logic status_i,
   input  logic force_hi_i,
   input  logic force_lo_i,
   output logic en_o
);
   always_comb begin
      if (force_lo_i)      en_o = 1'b0;
      else if (force_hi_i) en_o = 1'b1;
      else                 en_o = status_i;
   end
endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter #(
   parameter int WAIT_W      = 8,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_raw_i,
   input  logic [WAIT_W-1:0] lock_wait_i,
   input  logic [WAIT_W-1:0] unlock_wait_i,
   input  logic              force_en_hi_i,
   input  logic              force_en_lo_i,
   output logic              lock_status_o,
   output logic              lock_raw_o,
   output logic [CNT_W-1:0]  lock_count_o,
   output logic              load_en_o
);
   generate
      if (WAIT_W < 1 || WAIT_W > 16) begin : g_bad_wait
         $error("pll_lock_filter: WAIT_W must be 1..16");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("pll_lock_filter: CNT_W must be 1..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("pll_lock_filter: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic flag_sync;
   logic enter_pulse;

   plf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lock_raw_i),
      .q_o   (flag_sync)
   );

   plf_qualifier #(.WAIT_W(WAIT_W)) u_qual (
      .clk          (clk),
      .rst_n        (rst_n),
      .flag_i       (flag_sync),
      .enter_wait_i (lock_wait_i),
      .leave_wait_i (unlock_wait_i),
      .locked_o     (lock_status_o),
      .enter_o      (enter_pulse)
   );

   plf_event_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (enter_pulse),
      .count_o (lock_count_o)
   );

   plf_load_enable u_len (
      .status_i   (lock_status_o),
      .force_hi_i (force_en_hi_i),
      .force_lo_i (force_en_lo_i),
      .en_o       (load_en_o)
   );

   assign lock_raw_o = flag_sync;
endmodule

// File: rtl/pll_lock_filter_chk.sv
module pll_lock_filter_chk #(
   parameter int WAIT_W = 8,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lock_raw_i,
   input logic [WAIT_W-1:0] lock_wait_i,
   input logic [WAIT_W-1:0] unlock_wait_i,
   input logic              force_en_hi_i,
   input logic              force_en_lo_i,
   input logic              lock_status_o,
   input logic              lock_raw_o,
   input logic [CNT_W-1:0]  lock_count_o,
   input logic              load_en_o
);
   a_r6_follow_status: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_en_lo_i && !force_en_hi_i) |-> (load_en_o == lock_status_o));

   a_r7_force_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_en_lo_i && force_en_hi_i) |-> load_en_o);

   a_r8_force_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
      force_en_lo_i |-> !load_en_o);

   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_status_o) |-> (lock_count_o == CNT_W'($past(lock_count_o) + 1'b1)));

   a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(lock_status_o) |-> $stable(lock_count_o));

   a_r1_rise_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_status_o) |-> $past(lock_raw_o));

   a_r2_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_status_o) |-> !$past(lock_raw_o));

   a_r10_zero_lock_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_status_o && lock_raw_o && lock_wait_i == '0) |=> lock_status_o);

   a_r10_zero_unlock_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_status_o && !lock_raw_o && unlock_wait_i == '0) |=> !lock_status_o);
endmodule

bind pll_lock_filter pll_lock_filter_chk #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pll_lock_filter_bench.sv
module pll_lock_filter_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       raw = 1'b0;
   logic [7:0] lwait = 8'd0;
   logic [7:0] uwait = 8'd0;
   logic       fhi = 1'b0;
   logic       flo = 1'b0;
   logic       status, raw_o, len;
   logic [7:0] cnt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int exp_cnt = 0;

   always #10 clk = ~clk;

   pll_lock_filter u_pll_lock_filter (
      .clk(clk), .rst_n(rst_n), .lock_raw_i(raw),
      .lock_wait_i(lwait), .unlock_wait_i(uwait),
      .force_en_hi_i(fhi), .force_en_lo_i(flo),
      .lock_status_o(status), .lock_raw_o(raw_o),
      .lock_count_o(cnt), .load_en_o(len)
   );

   // vectors: lock wait, high samples, expected lock
   localparam int NV = 8;
   localparam int V_WAIT[NV] = '{0, 1, 3, 3, 10, 10, 255, 255};
   localparam int V_LEN [NV] = '{1, 1, 3, 4, 10, 11, 255, 256};
   localparam int V_LOCK[NV] = '{1, 0, 0, 1, 0,  1,  0,   1};

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic go_unlocked();
      uwait = 8'd0;
      raw   = 1'b0;
      step(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      step(3);
      check("R9 status", status, 0);
      check("R9 raw echo", raw_o, 0);
      check("R9 count", cnt, 0);
      check("R9 load enable", len, 0);
      rst_n = 1'b1;
      step(2);

      // vector table: R1/R10 lock qualification
      for (int i = 0; i < NV; i++) begin
         go_unlocked();
         uwait = 8'd255;
         lwait = 8'(V_WAIT[i]);
         raw   = 1'b1;
         step(V_LEN[i]);
         raw   = 1'b0;
         step(3);
         if (V_LOCK[i] != 0) exp_cnt = (exp_cnt + 1) % 256;
         check("R1 vector lock", status, V_LOCK[i]);
         check("R4 vector count", cnt, exp_cnt);
      end
      go_unlocked();

      // R1 exact edge for wait=2
      lwait = 8'd2;
      raw   = 1'b1;
      step(4);
      check("R1 not yet", status, 0);
      step(1);
      check("R1 rise edge", status, 1);
      exp_cnt = (exp_cnt + 1) % 256;

      // R2 unlock wait 5
      lwait = 8'd255;
      uwait = 8'd5;
      raw = 1'b0; step(5); raw = 1'b1; step(3);
      check("R2 five low samples keep lock", status, 1);
      raw = 1'b0; step(6); raw = 1'b1; step(3);
      check("R2 six low samples unlock", status, 0);
      go_unlocked();

      // R3 interrupted run
      lwait = 8'd4;
      raw = 1'b1; step(3);
      raw = 1'b0; step(1);
      raw = 1'b1; step(3);
      raw = 1'b0; step(3);
      check("R3 interrupted run", status, 0);
      check("R3 count unchanged", cnt, exp_cnt);

      // R5 synchronizer latency
      go_unlocked();
      lwait = 8'd255;
      raw = 1'b1;
      step(1);
      check("R5 after one edge", raw_o, 0);
      step(1);
      check("R5 after two edges", raw_o, 1);
      raw = 1'b0;
      step(3);

      // R6/R7/R8 overrides while unlocked
      check("R6 follow unlocked", len, 0);
      fhi = 1'b1; #1;
      check("R7 force high unlocked", len, 1);
      flo = 1'b1; #1;
      check("R8 both forces", len, 0);
      fhi = 1'b0; flo = 1'b0;

      // overrides while locked
      lwait = 8'd0; uwait = 8'd255;
      raw = 1'b1; step(3);
      exp_cnt = (exp_cnt + 1) % 256;
      check("R6 follow locked", len, 1);
      flo = 1'b1; #1;
      check("R8 force low locked", len, 0);
      fhi = 1'b1; #1;
      check("R8 low beats high locked", len, 0);
      flo = 1'b0; #1;
      check("R7 force high locked", len, 1);
      fhi = 1'b0;

      // R10 zero unlock wait
      uwait = 8'd0;
      raw = 1'b0; step(2);
      check("R10 not yet sampled", status, 1);
      step(1);
      check("R10 unlock on first low sample", status, 0);

      // R4 wrap: alternate every edge, one entry per pair
      lwait = 8'd0; uwait = 8'd0;
      for (int n = 0; n < (255 - exp_cnt); n++) begin
         raw = 1'b1; step(1);
         raw = 1'b0; step(1);
      end
      step(3);
      exp_cnt = 255;
      check("R4 reach 255", cnt, 255);
      raw = 1'b1; step(1);
      raw = 1'b0; step(3);
      check("R4 wrap to 0", cnt, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule